// File: doc/BRIEF.md
# Power-Management Capability Register Block

This block gives a bus device the configuration-space registers a host uses to discover and control its power state. The host reaches them through a simple configuration port. The address is a byte offset, and only its dword part is decoded. Write data carries four byte enables. Read data is combinational on the address.

The capability pointer sits at a fixed location and always points to offset 0x40. The capability structure at that offset holds seven registers:
- the capability pointer;
- the capability ID;
- the next-item pointer;
- the capabilities word;
- the control/status word;
- the bridge-support extension byte;
- the data byte.

Only the power-state field of the control/status word is writable.

The block holds one state machine with four states. PM_D0 is normal operation. PM_D1 idles the bus. PM_D2 stops clocks. PM_D3 powers the device down. An accepted host write moves the machine to the written state. There are three kinds of transition:
- DOWN: to a higher-numbered state.
- RESTORE: to a lower-numbered state.
- HOLD: the same state, or no accepted write.

A DOWN transition sets a sticky power-down request flag for the local processor. A RESTORE transition sets a sticky restore request flag. The local side clears either flag with a write-one-to-clear access. The current state is driven out so that local logic can idle the bus or gate clocks.

Top module: `pm_cap_regs`

## Requirements
- R1: A read at byte offset 0x34 returns 0x00000040: the capability pointer in bits [7:0] and zero elsewhere.
- R2: A read at offset 0x40 returns 0x06020001. Bits [7:0] are the capability ID 0x01 and bits [15:8] the next pointer 0x00. Bits [31:16] are the capabilities word 0x0602: version 3'b010 in [18:16], D1 support at bit 25 and D2 support at bit 26.
- R3: A read at offset 0x44 returns the current power state in bits [1:0], encoded 00=D0, 01=D1, 10=D2, 11=D3. All other bits, including the bridge extension byte [23:16] and the data byte [31:24], read zero.
- R4: After reset the state is D0, pwr_state is 2'b00, and irq_down and irq_up are both low.
- R5: A write to offset 0x44 with cfg_be[0] high is accepted and loads cfg_wdata[1:0] as the new state. pwr_state shows it from the cycle after the write.
- R6: An accepted write to a higher-numbered state (DOWN) sets irq_down in the cycle after the write.
- R7: An accepted write to a lower-numbered state (RESTORE) sets irq_up in the cycle after the write.
- R8: An accepted write of the current state (HOLD) sets neither flag.
- R9: A write to offset 0x44 with cfg_be[0] low changes nothing. So does a write to any other offset.
- R10: Both flags stay set until a local write with loc_clr_wr high clears them. Bit 0 of loc_clr clears irq_down and bit 1 clears irq_up. A zero bit leaves its flag alone.
- R11: If a flag is set and cleared in the same cycle, the set wins.
- R12: Reads of unmapped offsets, such as 0x00 and 0x48, return zero. Writes to the read-only offsets 0x34 and 0x40 leave their contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (dword aligned) |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| loc_clr_wr | input | 1 | Local flag-clear strobe |
| loc_clr | input | 2 | Write-one-to-clear mask: bit 0 down, bit 1 restore |
| pwr_state | output | 2 | Current power state |
| irq_down | output | 1 | Power-down request flag |
| irq_up | output | 1 | Restore request flag |

## Verification
Some rules are checked on every cycle by the assertions:
- the state loaded by an accepted write appears one cycle later;
- the state is stable when no write is accepted;
- DOWN and RESTORE writes set their flags, and HOLD writes leave irq_down clear;
- flags stay set unless they are cleared;
- the 0x44 read tracks the state.

The bench's scenarios are needed for the rest:
- the constant capability words;
- zero reads at unmapped offsets;
- the ignored writes with byte enable 0 low or to read-only offsets;
- each clear bit acting alone;
- the set-over-clear priority within one cycle.

// File: rtl/pmcap_pkg.sv
package pmcap_pkg;

    typedef enum logic [1:0] {
        PM_D0 = 2'd0,
        PM_D1 = 2'd1,
        PM_D2 = 2'd2,
        PM_D3 = 2'd3
    } pm_state_e;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_DOWN = 0;
    localparam int FLAG_UP   = 1;

    localparam logic [7:0] CAP_ID_PM   = 8'h01;
    localparam logic [7:0] CAP_NEXT    = 8'h00;
    localparam logic [2:0] PM_VERSION  = 3'b010;

    // capabilities word: [2:0] version, [9] D1 support, [10] D2 support
    function automatic logic [15:0] pmc_word(input logic d1_ok, input logic d2_ok);
        return {5'b0, d2_ok, d1_ok, 6'b0, PM_VERSION};
    endfunction

endpackage

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import pmcap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_accept,
    input  logic [1:0] wr_state,
    output pm_state_e cur_state,
    output logic      req_down,
    output logic      req_up
);

    pm_state_e nxt_state;
    pm_state_e cur_q;

    always_comb begin
        nxt_state = cur_q;
        if (wr_accept) begin
            nxt_state = pm_state_e'(wr_state);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= PM_D0;
        end else begin
            cur_q <= nxt_state;
        end
    end

    // classify the requested transition as DOWN, RESTORE or HOLD
    always_comb begin
        req_down = 1'b0;
        req_up   = 1'b0;
        if (wr_accept) begin
            unique case (cur_q)
                PM_D0: begin
                    req_down = (wr_state != 2'd0);
                end
                PM_D1: begin
                    req_down = (wr_state >= 2'd2);
                    req_up   = (wr_state == 2'd0);
                end
                PM_D2: begin
                    req_down = (wr_state == 2'd3);
                    req_up   = (wr_state <= 2'd1);
                end
                PM_D3: begin
                    req_up   = (wr_state != 2'd3);
                end
            endcase
        end
    end

    assign cur_state = cur_q;

endmodule

// File: rtl/pm_irq_flags.sv
module pm_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_req,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (set_req[g]) begin
                flag_q <= 1'b1;
            end else if (clr_wr && clr_mask[g]) begin
                flag_q <= 1'b0;
            end
        end
        assign flags[g] = flag_q;
    end

endmodule

// File: rtl/pm_cfg_readmux.sv
module pm_cfg_readmux
    import pmcap_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  PTR_OFS = 8'h34,
    parameter logic [7:0]  CAP_OFS = 8'h40
) (
    input  logic [ADDR_W-3:0] dw_addr,
    input  pm_state_e         cur_state,
    output logic [31:0]       rdata
);

    localparam logic [ADDR_W-1:0] PTR_A   = ADDR_W'(PTR_OFS);
    localparam logic [ADDR_W-1:0] CAP_A   = ADDR_W'(CAP_OFS);
    localparam logic [ADDR_W-1:0] CSR_A   = ADDR_W'(CAP_OFS + 8'd4);
    localparam logic [ADDR_W-3:0] PTR_DW  = PTR_A[ADDR_W-1:2];
    localparam logic [ADDR_W-3:0] CAP_DW  = CAP_A[ADDR_W-1:2];
    localparam logic [ADDR_W-3:0] CSR_DW  = CSR_A[ADDR_W-1:2];

    always_comb begin
        rdata = '0;
        if (dw_addr == PTR_DW) begin
            rdata = {24'b0, CAP_OFS};
        end else if (dw_addr == CAP_DW) begin
            rdata = {pmc_word(1'b1, 1'b1), CAP_NEXT, CAP_ID_PM};
        end else if (dw_addr == CSR_DW) begin
            // data byte and bridge byte read zero; PMCSR holds state only
            rdata = {8'h00, 8'h00, 14'b0, cur_state};
        end
    end

endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
    import pmcap_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  PTR_OFS = 8'h34,
    parameter logic [7:0]  CAP_OFS = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              loc_clr_wr,
    input  logic [1:0]        loc_clr,
    output logic [1:0]        pwr_state,
    output logic              irq_down,
    output logic              irq_up
);

    localparam logic [ADDR_W-1:0] CSR_A  = ADDR_W'(CAP_OFS + 8'd4);
    localparam logic [ADDR_W-3:0] CSR_DW = CSR_A[ADDR_W-1:2];

    pm_state_e            cur_state;
    logic                 wr_accept;
    logic                 req_down;
    logic                 req_up;
    logic [NUM_FLAGS-1:0] set_req;
    logic [NUM_FLAGS-1:0] flags;
    logic                 unused_bits;

    assign wr_accept = cfg_wr && cfg_be[0] && (cfg_addr[ADDR_W-1:2] == CSR_DW);
    assign unused_bits = ^{cfg_wdata[31:2], cfg_be[3:1], cfg_addr[1:0]};

    pm_state_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_accept (wr_accept),
        .wr_state  (cfg_wdata[1:0]),
        .cur_state (cur_state),
        .req_down  (req_down),
        .req_up    (req_up)
    );

    always_comb begin
        set_req            = '0;
        set_req[FLAG_DOWN] = req_down;
        set_req[FLAG_UP]   = req_up;
    end

    pm_irq_flags #(.N(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_req  (set_req),
        .clr_wr   (loc_clr_wr),
        .clr_mask (loc_clr),
        .flags    (flags)
    );

    pm_cfg_readmux #(
        .ADDR_W  (ADDR_W),
        .PTR_OFS (PTR_OFS),
        .CAP_OFS (CAP_OFS)
    ) u_rmux (
        .dw_addr   (cfg_addr[ADDR_W-1:2]),
        .cur_state (cur_state),
        .rdata     (cfg_rdata)
    );

    assign pwr_state = cur_state;
    assign irq_down  = flags[FLAG_DOWN];
    assign irq_up    = flags[FLAG_UP];

endmodule

// File: rtl/pm_cap_regs_chk.sv
module pm_cap_regs_chk #(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  CAP_OFS = 8'h40
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic              loc_clr_wr,
    input logic [1:0]        loc_clr,
    input logic [1:0]        pwr_state,
    input logic              irq_down,
    input logic              irq_up
);

    localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CAP_OFS + 8'd4);

    logic acc;
    assign acc = cfg_wr && cfg_be[0] && (cfg_addr[ADDR_W-1:2] == CSR_A[ADDR_W-1:2]);

    a_r4_reset_state: assert property (@(posedge clk)
        rst |=> (pwr_state == 2'b00 && !irq_down && !irq_up));

    a_r5_state_load: assert property (@(posedge clk) disable iff (rst)
        acc |=> (pwr_state == $past(cfg_wdata[1:0])));

    a_r9_state_hold: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(pwr_state));

    a_r6_down_sets: assert property (@(posedge clk) disable iff (rst)
        (acc && cfg_wdata[1:0] > pwr_state) |=> irq_down);

    a_r7_up_sets: assert property (@(posedge clk) disable iff (rst)
        (acc && cfg_wdata[1:0] < pwr_state) |=> irq_up);

    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (acc && cfg_wdata[1:0] == pwr_state && !irq_down) |=> !irq_down);

    a_r10_down_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_down && !(loc_clr_wr && loc_clr[0])) |=> irq_down);

    a_r10_up_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_up && !(loc_clr_wr && loc_clr[1])) |=> irq_up);

    a_r3_csr_read: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == CSR_A) |-> (cfg_rdata == {30'b0, pwr_state}));

endmodule

bind pm_cap_regs pm_cap_regs_chk #(
    .ADDR_W  (ADDR_W),
    .CAP_OFS (CAP_OFS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .loc_clr_wr (loc_clr_wr),
    .loc_clr    (loc_clr),
    .pwr_state  (pwr_state),
    .irq_down   (irq_down),
    .irq_up     (irq_up)
);

// File: tb/tb_pm_cap_regs.sv
module tb_pm_cap_regs;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [7:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        loc_clr_wr;
    logic [1:0]  loc_clr;
    logic [1:0]  pwr_state;
    logic        irq_down;
    logic        irq_up;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pm_cap_regs dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .loc_clr_wr (loc_clr_wr),
        .loc_clr    (loc_clr),
        .pwr_state  (pwr_state),
        .irq_down   (irq_down),
        .irq_up     (irq_up)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // one clock cycle of stimulus, driven and released at negedges
    task automatic cycle(input logic wr, input logic [7:0] a, input logic [3:0] be,
                         input logic [31:0] d, input logic cw, input logic [1:0] cm);
        cfg_wr = wr; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        loc_clr_wr = cw; loc_clr = cm;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; loc_clr_wr = 1'b0; loc_clr = 2'b00; cfg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        cfg_addr = a;
        #1;
        v = cfg_rdata;
    endtask

    task automatic flags(input string req, input logic d, input logic u);
        check(req, "irq_down", {31'b0, irq_down}, {31'b0, d});
        check(req, "irq_up",   {31'b0, irq_up},   {31'b0, u});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst = 1'b1;
        cycle(1'b0, 8'h00, 4'h0, 0, 1'b0, 2'b00);
        cycle(1'b0, 8'h00, 4'h0, 0, 1'b0, 2'b00);
        rst = 1'b0;
        check("R4", "pwr_state", {30'b0, pwr_state}, 0);
        flags("R4", 1'b0, 1'b0);
        rd(8'h44, v);
        check("R4", "csr read", v, 32'h0);
    endtask

    task automatic t_constants();
        logic [31:0] v;
        rd(8'h34, v); check("R1", "cap pointer", v, 32'h0000_0040);
        rd(8'h40, v); check("R2", "cap header", v, 32'h0602_0001);
        rd(8'h00, v); check("R12", "unmapped 0x00", v, 32'h0);
        rd(8'h48, v); check("R12", "unmapped 0x48", v, 32'h0);
        cycle(1'b1, 8'h34, 4'hF, 32'hFFFF_FFFF, 1'b0, 2'b00);
        cycle(1'b1, 8'h40, 4'hF, 32'hFFFF_FFFF, 1'b0, 2'b00);
        rd(8'h34, v); check("R12", "ptr after write", v, 32'h0000_0040);
        rd(8'h40, v); check("R12", "hdr after write", v, 32'h0602_0001);
        check("R9", "state after ro writes", {30'b0, pwr_state}, 0);
    endtask

    task automatic t_down();
        logic [31:0] v;
        cycle(1'b1, 8'h44, 4'h1, 32'hFFFF_FF02, 1'b0, 2'b00);
        check("R5", "pwr_state D2", {30'b0, pwr_state}, 2);
        flags("R6", 1'b1, 1'b0);
        rd(8'h44, v); check("R3", "csr read D2", v, 32'h2);
    endtask

    task automatic t_clear();
        cycle(1'b0, 8'h00, 4'h0, 0, 1'b1, 2'b10);
        flags("R10", 1'b1, 1'b0);
        cycle(1'b0, 8'h00, 4'h0, 0, 1'b0, 2'b00);
        flags("R10", 1'b1, 1'b0);
        cycle(1'b0, 8'h00, 4'h0, 0, 1'b1, 2'b01);
        flags("R10", 1'b0, 1'b0);
    endtask

    task automatic t_hold();
        cycle(1'b1, 8'h44, 4'h1, 32'h2, 1'b0, 2'b00);
        check("R8", "pwr_state", {30'b0, pwr_state}, 2);
        flags("R8", 1'b0, 1'b0);
    endtask

    task automatic t_restore();
        cycle(1'b1, 8'h44, 4'h1, 32'h1, 1'b0, 2'b00);
        check("R5", "pwr_state D1", {30'b0, pwr_state}, 1);
        flags("R7", 1'b0, 1'b1);
        cycle(1'b0, 8'h00, 4'h0, 0, 1'b1, 2'b10);
        flags("R10", 1'b0, 1'b0);
    endtask

    task automatic t_ignored();
        cycle(1'b1, 8'h44, 4'hE, 32'h3, 1'b0, 2'b00);
        check("R9", "be0 low state", {30'b0, pwr_state}, 1);
        flags("R9", 1'b0, 1'b0);
        cycle(1'b1, 8'h48, 4'hF, 32'h3, 1'b0, 2'b00);
        check("R9", "other addr state", {30'b0, pwr_state}, 1);
        flags("R9", 1'b0, 1'b0);
    endtask

    task automatic t_set_wins();
        cycle(1'b1, 8'h44, 4'h1, 32'h3, 1'b1, 2'b01);
        check("R5", "pwr_state D3", {30'b0, pwr_state}, 3);
        flags("R11", 1'b1, 1'b0);
        cycle(1'b1, 8'h44, 4'h1, 32'h0, 1'b1, 2'b11);
        check("R5", "pwr_state D0", {30'b0, pwr_state}, 0);
        flags("R11", 1'b0, 1'b1);
    endtask

    initial begin
        cfg_wr = 0; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0;
        loc_clr_wr = 0; loc_clr = 0; rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_constants();
        t_down();
        t_clear();
        t_hold();
        t_restore();
        t_ignored();
        t_set_wins();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule